// File: doc/BRIEF.md
# Strap-Configured Shared Pin Multiplexer

This block decides which internal function owns each shared package pin, and in which direction each pin is driven. It handles two groups of pins. The first group is shared between a boot memory/IO bus and a set of low-speed peripherals or general-purpose IO. The second group is the upper half of a wide SDRAM data bus, plus its data-mask lines, and it can be given to a PCI bus or to a second Ethernet port instead.

Three straps are sampled once, on the first rising edge after reset is released. One strap sets the starting owner of every pin in the boot-bus group. After that, software can move any single pin in this group to the boot bus, to its alternative peripheral, or to GPIO. The other two straps fix the mode of the upper group until the next reset.

A small sequencer runs after reset. It has three states. LATCH captures the straps. INIT loads the per-pin selection from the captured strap. RUN is the normal operating state. The sequence always runs LATCH→INIT→RUN, RUN holds until reset, and reset always returns it to LATCH. No pad is driven until RUN.

Top module: `pinmux_ctrl`

## Requirements
- R1: While reset is asserted, and until the second rising edge after reset is released, `ready` is 0 and every output enable (`sh_pad_oe`, `up_pad_oe`, `dqm_pad_oe`) is 0. From that edge onward `ready` is 1.
- R2: The straps are captured on the first rising edge after reset release. Once `ready` is 1, every pin's 2-bit selection in `cur_sel` (pin i at bits 2i+1:2i) holds 00 (boot bus) if `strap_prom_alt` was 0, or 01 (alternative) if it was 1.
- R3: A boot-group pin follows its selection. Code 00 drives it from `prom_do`/`prom_oe`, code 01 from `alt_do`/`alt_oe`, and code 10 from `gpio_do`/`gpio_oe`.
- R4: When `ready` is 1 and `sel_we` is 1, the next rising edge loads `sel_val` into the selection of pin `sel_idx` only. The value 11 is reserved, and a write of 11 changes no selection.
- R5: Input routing in the boot group works as follows. `prom_di[i]` copies the pad only under code 00 and is 0 otherwise. `alt_di[i]` copies the pad under code 01, or always if bit i of `TIE_MASK` is set, and is 0 otherwise. `gpio_di` always copies the pad.
- R6: If `strap_mem_narrow` was 0, `upper_mode` is 0 (SDRAM). The upper pads carry `sdr_do`, every upper enable equals `sdr_oe`, and `sdr_di` copies the pads. `eth_rxd` and `pci_di` are 0.
- R7: If `strap_mem_narrow` was 1 and `strap_pci` was 0, `upper_mode` is 1 (Ethernet). The top `ETH_TX` upper pins are always outputs, with `eth_tx[k]` on pin `N_UP-ETH_TX+k`. The pins below them are inputs routed to `eth_rxd`, and their output value is 0.
- R8: If `strap_mem_narrow` was 1 and `strap_pci` was 1, `upper_mode` is 2 (PCI). Each upper pin takes `pci_do`/`pci_oe`, and `pci_di` copies the pads.
- R9: In SDRAM mode the mask pads carry `sdr_dqm` with enable `sdr_oe`, and `dqm_clk` is 0. In the other modes the mask enables are 0 and `dqm_clk` copies the mask pads.
- R10: Changing any strap after it has been captured does not change `upper_mode` or the upper pin behaviour. Only a new reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_prom_alt | input | 1 | Strap: boot-group pins start on the alternative function |
| strap_mem_narrow | input | 1 | Strap: SDRAM uses the lower half only |
| strap_pci | input | 1 | Strap: narrow mode gives the upper pins to PCI rather than Ethernet |
| sel_we | input | 1 | Per-pin selection write strobe |
| sel_idx | input | IDXW | Pin index for the write |
| sel_val | input | 2 | Selection code: 00 boot bus, 01 alternative, 10 GPIO, 11 reserved |
| prom_do | input | N_SH | Boot-bus output values |
| prom_oe | input | N_SH | Boot-bus output enables |
| alt_do | input | N_SH | Alternative-function output values |
| alt_oe | input | N_SH | Alternative-function output enables |
| gpio_do | input | N_SH | GPIO data register |
| gpio_oe | input | N_SH | GPIO direction register |
| sh_pad_di | input | N_SH | Boot-group pad input values |
| sh_pad_do | output | N_SH | Boot-group pad output values |
| sh_pad_oe | output | N_SH | Boot-group pad output enables |
| prom_di | output | N_SH | Pad inputs routed to the boot bus |
| alt_di | output | N_SH | Pad inputs routed to the alternative functions |
| gpio_di | output | N_SH | Pad inputs routed to GPIO |
| cur_sel | output | 2*N_SH | Current per-pin selection codes |
| sdr_do | input | N_UP | SDRAM upper data out |
| sdr_oe | input | 1 | SDRAM data/mask output enable |
| sdr_dqm | input | N_DQM | SDRAM upper data masks |
| eth_tx | input | ETH_TX | Ethernet port 1 transmit data, enable and error |
| pci_do | input | N_UP | PCI address/data out |
| pci_oe | input | N_UP | PCI address/data enables |
| up_pad_di | input | N_UP | Upper pad input values |
| up_pad_do | output | N_UP | Upper pad output values |
| up_pad_oe | output | N_UP | Upper pad output enables |
| sdr_di | output | N_UP | Upper pads routed to SDRAM |
| eth_rxd | output | N_UP-ETH_TX | Lower upper pads routed to Ethernet receive |
| pci_di | output | N_UP | Upper pads routed to PCI |
| dqm_pad_di | input | N_DQM | Mask pad input values |
| dqm_pad_do | output | N_DQM | Mask pad output values |
| dqm_pad_oe | output | N_DQM | Mask pad output enables |
| dqm_clk | output | N_DQM | Mask pads used as clock inputs |
| upper_mode | output | 2 | 0 SDRAM, 1 Ethernet, 2 PCI |
| ready | output | 1 | Sequencer is in RUN |

## Verification
Pad outputs and routed inputs are combinational from the held selection and mode, so they are due in the same cycle as their source inputs. A selection write shows up one rising edge after the strobe. `ready` and the strap-derived values show up two rising edges after reset is released: LATCH at the first edge, INIT at the second. Inputs change just after a falling edge, and every queued expectation is compared at the next falling edge, so each comparison falls exactly one clock edge after the stimulus. The reset sequence deliberately spans the LATCH and INIT edges before any check relies on RUN.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    typedef enum logic [1:0] {
        PS_PRIMARY = 2'b00,
        PS_ALT     = 2'b01,
        PS_GPIO    = 2'b10,
        PS_RSVD    = 2'b11
    } pin_sel_e;

    typedef enum logic [1:0] {
        UM_SDRAM = 2'd0,
        UM_ETH   = 2'd1,
        UM_PCI   = 2'd2
    } up_mode_e;

    typedef enum logic [1:0] {
        BS_LATCH = 2'd0,
        BS_INIT  = 2'd1,
        BS_RUN   = 2'd2
    } boot_state_e;

endpackage

// File: rtl/pinmux_boot_seq.sv
module pinmux_boot_seq
    import pinmux_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strap_prom_alt,
    input  logic     strap_mem_narrow,
    input  logic     strap_pci,
    output logic     run,
    output logic     init_load,
    output logic     prom_alt_q,
    output up_mode_e mode_q
);

    boot_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BS_LATCH;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BS_LATCH: st_d = BS_INIT;
            BS_INIT:  st_d = BS_RUN;
            BS_RUN:   st_d = BS_RUN;
            default:  st_d = BS_LATCH;
        endcase
    end

    // strap capture, only in LATCH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prom_alt_q <= 1'b0;
            mode_q     <= UM_SDRAM;
        end else if (st_q == BS_LATCH) begin
            prom_alt_q <= strap_prom_alt;
            if (!strap_mem_narrow) mode_q <= UM_SDRAM;
            else if (strap_pci)    mode_q <= UM_PCI;
            else                   mode_q <= UM_ETH;
        end
    end

    // state outputs
    always_comb begin
        run       = 1'b0;
        init_load = 1'b0;
        unique case (st_q)
            BS_LATCH: ;
            BS_INIT:  init_load = 1'b1;
            BS_RUN:   run = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/pinmux_shared_bank.sv
module pinmux_shared_bank
    import pinmux_pkg::*;
#(
    parameter int unsigned N_SH = 8,
    parameter int unsigned IDXW = 3,
    parameter logic [N_SH-1:0] TIE_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              init_load,
    input  logic              prom_alt_q,
    input  logic              sel_we,
    input  logic [IDXW-1:0]   sel_idx,
    input  logic [1:0]        sel_val,
    input  logic [N_SH-1:0]   prom_do,
    input  logic [N_SH-1:0]   prom_oe,
    input  logic [N_SH-1:0]   alt_do,
    input  logic [N_SH-1:0]   alt_oe,
    input  logic [N_SH-1:0]   gpio_do,
    input  logic [N_SH-1:0]   gpio_oe,
    input  logic [N_SH-1:0]   pad_di,
    output logic [N_SH-1:0]   pad_do,
    output logic [N_SH-1:0]   pad_oe,
    output logic [N_SH-1:0]   prom_di,
    output logic [N_SH-1:0]   alt_di,
    output logic [N_SH-1:0]   gpio_di,
    output logic [2*N_SH-1:0] cur_sel
);

    logic wr_ok;
    assign wr_ok = run & sel_we & (sel_val != PS_RSVD);

    assign gpio_di = pad_di;

    for (genvar i = 0; i < N_SH; i++) begin : g_pin
        logic [1:0] sel_q;
        logic       d_l, oe_l, pdi_l, adi_l;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sel_q <= PS_PRIMARY;
            else if (init_load)
                sel_q <= prom_alt_q ? PS_ALT : PS_PRIMARY;
            else if (wr_ok && (sel_idx == IDXW'(i)))
                sel_q <= sel_val;
        end

        always_comb begin
            d_l   = 1'b0;
            oe_l  = 1'b0;
            pdi_l = 1'b0;
            adi_l = TIE_MASK[i] ? pad_di[i] : 1'b0;
            unique case (sel_q)
                PS_PRIMARY: begin
                    d_l   = prom_do[i];
                    oe_l  = prom_oe[i];
                    pdi_l = pad_di[i];
                end
                PS_ALT: begin
                    d_l   = alt_do[i];
                    oe_l  = alt_oe[i];
                    adi_l = pad_di[i];
                end
                PS_GPIO: begin
                    d_l   = gpio_do[i];
                    oe_l  = gpio_oe[i];
                end
                default: ;
            endcase
        end

        assign pad_do[i]        = d_l;
        assign pad_oe[i]        = oe_l & run;
        assign prom_di[i]       = pdi_l;
        assign alt_di[i]        = adi_l;
        assign cur_sel[2*i +: 2] = sel_q;
    end

endmodule

// File: rtl/pinmux_upper_bank.sv
module pinmux_upper_bank
    import pinmux_pkg::*;
#(
    parameter int unsigned N_UP   = 16,
    parameter int unsigned ETH_TX = 10,
    parameter int unsigned N_DQM  = 2
) (
    input  logic                   run,
    input  up_mode_e               mode,
    input  logic [N_UP-1:0]        sdr_do,
    input  logic                   sdr_oe,
    input  logic [N_DQM-1:0]       sdr_dqm,
    input  logic [ETH_TX-1:0]      eth_tx,
    input  logic [N_UP-1:0]        pci_do,
    input  logic [N_UP-1:0]        pci_oe,
    input  logic [N_UP-1:0]        pad_di,
    output logic [N_UP-1:0]        pad_do,
    output logic [N_UP-1:0]        pad_oe,
    output logic [N_UP-1:0]        sdr_di,
    output logic [N_UP-ETH_TX-1:0] eth_rxd,
    output logic [N_UP-1:0]        pci_di,
    input  logic [N_DQM-1:0]       dqm_di,
    output logic [N_DQM-1:0]       dqm_do,
    output logic [N_DQM-1:0]       dqm_oe,
    output logic [N_DQM-1:0]       dqm_clk
);

    localparam int unsigned ETH_BASE = N_UP - ETH_TX;

    for (genvar i = 0; i < N_UP; i++) begin : g_up
        logic d_l, oe_l, sdi_l, pdi_l;
        if (i >= ETH_BASE) begin : g_tx
            // top pins: transmit outputs in Ethernet mode
            always_comb begin
                d_l = 1'b0; oe_l = 1'b0; sdi_l = 1'b0; pdi_l = 1'b0;
                unique case (mode)
                    UM_SDRAM: begin d_l = sdr_do[i]; oe_l = sdr_oe;    sdi_l = pad_di[i]; end
                    UM_ETH:   begin d_l = eth_tx[i-ETH_BASE]; oe_l = 1'b1; end
                    UM_PCI:   begin d_l = pci_do[i]; oe_l = pci_oe[i]; pdi_l = pad_di[i]; end
                    default:  ;
                endcase
            end
        end else begin : g_rx
            // lower pins: receive inputs in Ethernet mode
            logic rdi_l;
            always_comb begin
                d_l = 1'b0; oe_l = 1'b0; sdi_l = 1'b0; pdi_l = 1'b0; rdi_l = 1'b0;
                unique case (mode)
                    UM_SDRAM: begin d_l = sdr_do[i]; oe_l = sdr_oe;    sdi_l = pad_di[i]; end
                    UM_ETH:   rdi_l = pad_di[i];
                    UM_PCI:   begin d_l = pci_do[i]; oe_l = pci_oe[i]; pdi_l = pad_di[i]; end
                    default:  ;
                endcase
            end
            assign eth_rxd[i] = rdi_l;
        end
        assign pad_do[i] = d_l;
        assign pad_oe[i] = oe_l & run;
        assign sdr_di[i] = sdi_l;
        assign pci_di[i] = pdi_l;
    end

    for (genvar j = 0; j < N_DQM; j++) begin : g_dqm
        logic d_l, oe_l, ck_l;
        always_comb begin
            d_l = 1'b0; oe_l = 1'b0; ck_l = 1'b0;
            if (mode == UM_SDRAM) begin
                d_l  = sdr_dqm[j];
                oe_l = sdr_oe;
            end else begin
                ck_l = dqm_di[j];
            end
        end
        assign dqm_do[j]  = d_l;
        assign dqm_oe[j]  = oe_l & run;
        assign dqm_clk[j] = ck_l;
    end

endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
    import pinmux_pkg::*;
#(
    parameter int unsigned N_SH   = 8,
    parameter int unsigned N_UP   = 16,
    parameter int unsigned ETH_TX = 10,
    parameter int unsigned N_DQM  = 2,
    parameter logic [N_SH-1:0] TIE_MASK = N_SH'(12),
    localparam int unsigned IDXW  = (N_SH > 1) ? $clog2(N_SH) : 1,
    localparam int unsigned N_RX  = N_UP - ETH_TX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_prom_alt,
    input  logic              strap_mem_narrow,
    input  logic              strap_pci,
    input  logic              sel_we,
    input  logic [IDXW-1:0]   sel_idx,
    input  logic [1:0]        sel_val,
    input  logic [N_SH-1:0]   prom_do,
    input  logic [N_SH-1:0]   prom_oe,
    input  logic [N_SH-1:0]   alt_do,
    input  logic [N_SH-1:0]   alt_oe,
    input  logic [N_SH-1:0]   gpio_do,
    input  logic [N_SH-1:0]   gpio_oe,
    input  logic [N_SH-1:0]   sh_pad_di,
    output logic [N_SH-1:0]   sh_pad_do,
    output logic [N_SH-1:0]   sh_pad_oe,
    output logic [N_SH-1:0]   prom_di,
    output logic [N_SH-1:0]   alt_di,
    output logic [N_SH-1:0]   gpio_di,
    output logic [2*N_SH-1:0] cur_sel,
    input  logic [N_UP-1:0]   sdr_do,
    input  logic              sdr_oe,
    input  logic [N_DQM-1:0]  sdr_dqm,
    input  logic [ETH_TX-1:0] eth_tx,
    input  logic [N_UP-1:0]   pci_do,
    input  logic [N_UP-1:0]   pci_oe,
    input  logic [N_UP-1:0]   up_pad_di,
    output logic [N_UP-1:0]   up_pad_do,
    output logic [N_UP-1:0]   up_pad_oe,
    output logic [N_UP-1:0]   sdr_di,
    output logic [N_RX-1:0]   eth_rxd,
    output logic [N_UP-1:0]   pci_di,
    input  logic [N_DQM-1:0]  dqm_pad_di,
    output logic [N_DQM-1:0]  dqm_pad_do,
    output logic [N_DQM-1:0]  dqm_pad_oe,
    output logic [N_DQM-1:0]  dqm_clk,
    output logic [1:0]        upper_mode,
    output logic              ready
);

    logic     run, init_load, prom_alt_q;
    up_mode_e mode_q;

    pinmux_boot_seq u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .strap_prom_alt   (strap_prom_alt),
        .strap_mem_narrow (strap_mem_narrow),
        .strap_pci        (strap_pci),
        .run              (run),
        .init_load        (init_load),
        .prom_alt_q       (prom_alt_q),
        .mode_q           (mode_q)
    );

    pinmux_shared_bank #(.N_SH(N_SH), .IDXW(IDXW), .TIE_MASK(TIE_MASK)) u_sh (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .init_load  (init_load),
        .prom_alt_q (prom_alt_q),
        .sel_we     (sel_we),
        .sel_idx    (sel_idx),
        .sel_val    (sel_val),
        .prom_do    (prom_do),
        .prom_oe    (prom_oe),
        .alt_do     (alt_do),
        .alt_oe     (alt_oe),
        .gpio_do    (gpio_do),
        .gpio_oe    (gpio_oe),
        .pad_di     (sh_pad_di),
        .pad_do     (sh_pad_do),
        .pad_oe     (sh_pad_oe),
        .prom_di    (prom_di),
        .alt_di     (alt_di),
        .gpio_di    (gpio_di),
        .cur_sel    (cur_sel)
    );

    pinmux_upper_bank #(.N_UP(N_UP), .ETH_TX(ETH_TX), .N_DQM(N_DQM)) u_up (
        .run     (run),
        .mode    (mode_q),
        .sdr_do  (sdr_do),
        .sdr_oe  (sdr_oe),
        .sdr_dqm (sdr_dqm),
        .eth_tx  (eth_tx),
        .pci_do  (pci_do),
        .pci_oe  (pci_oe),
        .pad_di  (up_pad_di),
        .pad_do  (up_pad_do),
        .pad_oe  (up_pad_oe),
        .sdr_di  (sdr_di),
        .eth_rxd (eth_rxd),
        .pci_di  (pci_di),
        .dqm_di  (dqm_pad_di),
        .dqm_do  (dqm_pad_do),
        .dqm_oe  (dqm_pad_oe),
        .dqm_clk (dqm_clk)
    );

    assign upper_mode = mode_q;
    assign ready      = run;

endmodule

// File: rtl/pinmux_ctrl_chk.sv
module pinmux_ctrl_chk #(
    parameter int unsigned N_SH   = 8,
    parameter int unsigned N_UP   = 16,
    parameter int unsigned ETH_TX = 10,
    parameter int unsigned N_DQM  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              sel_we,
    input logic [1:0]        sel_val,
    input logic [2*N_SH-1:0] cur_sel,
    input logic [N_SH-1:0]   sh_pad_oe,
    input logic [N_UP-1:0]   up_pad_oe,
    input logic [N_DQM-1:0]  dqm_pad_oe,
    input logic [1:0]        upper_mode
);

    localparam logic [N_UP-1:0] ETH_OE = {N_UP{1'b1}} << (N_UP - ETH_TX);

    a_r1_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (sh_pad_oe == '0 && up_pad_oe == '0 && dqm_pad_oe == '0));

    a_r4_reserved_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && sel_we && sel_val == 2'b11) |=> $stable(cur_sel));

    a_r7_eth_directions: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && upper_mode == 2'd1) |-> (up_pad_oe == ETH_OE));

    a_r9_mask_pins_input: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && upper_mode != 2'd0) |-> (dqm_pad_oe == '0));

    a_r10_mode_static: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(upper_mode));

endmodule

bind pinmux_ctrl pinmux_ctrl_chk #(
    .N_SH(N_SH), .N_UP(N_UP), .ETH_TX(ETH_TX), .N_DQM(N_DQM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .sel_we     (sel_we),
    .sel_val    (sel_val),
    .cur_sel    (cur_sel),
    .sh_pad_oe  (sh_pad_oe),
    .up_pad_oe  (up_pad_oe),
    .dqm_pad_oe (dqm_pad_oe),
    .upper_mode (upper_mode)
);

// File: tb/pinmux_ctrl_test.sv
module pinmux_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_SH = 8, N_UP = 16, ETH_TX = 10, N_DQM = 2;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n = 1'b0;
    logic strap_prom_alt = 0, strap_mem_narrow = 0, strap_pci = 0;
    logic sel_we = 0;
    logic [2:0] sel_idx = '0;
    logic [1:0] sel_val = '0;
    logic [N_SH-1:0] prom_do = 8'hA5, prom_oe = 8'hF0, alt_do = 8'h3C, alt_oe = 8'h0F;
    logic [N_SH-1:0] gpio_do = 8'h96, gpio_oe = 8'hCC, sh_pad_di = 8'h5A;
    logic [N_SH-1:0] sh_pad_do, sh_pad_oe, prom_di, alt_di, gpio_di;
    logic [2*N_SH-1:0] cur_sel;
    logic [N_UP-1:0] sdr_do = 16'h1234, pci_do = 16'hC3A5, pci_oe = 16'h00FF, up_pad_di = 16'hBEEF;
    logic sdr_oe = 1'b1;
    logic [N_DQM-1:0] sdr_dqm = 2'b10, dqm_pad_di = 2'b01;
    logic [ETH_TX-1:0] eth_tx = 10'h2A5;
    logic [N_UP-1:0] up_pad_do, up_pad_oe, sdr_di, pci_di;
    logic [N_UP-ETH_TX-1:0] eth_rxd;
    logic [N_DQM-1:0] dqm_pad_do, dqm_pad_oe, dqm_clk;
    logic [1:0] upper_mode;
    logic ready;

    pinmux_ctrl uut (
        .clk(clk), .rst_n(rst_n), .strap_prom_alt(strap_prom_alt),
        .strap_mem_narrow(strap_mem_narrow), .strap_pci(strap_pci),
        .sel_we(sel_we), .sel_idx(sel_idx), .sel_val(sel_val),
        .prom_do(prom_do), .prom_oe(prom_oe), .alt_do(alt_do), .alt_oe(alt_oe),
        .gpio_do(gpio_do), .gpio_oe(gpio_oe), .sh_pad_di(sh_pad_di),
        .sh_pad_do(sh_pad_do), .sh_pad_oe(sh_pad_oe), .prom_di(prom_di),
        .alt_di(alt_di), .gpio_di(gpio_di), .cur_sel(cur_sel),
        .sdr_do(sdr_do), .sdr_oe(sdr_oe), .sdr_dqm(sdr_dqm), .eth_tx(eth_tx),
        .pci_do(pci_do), .pci_oe(pci_oe), .up_pad_di(up_pad_di),
        .up_pad_do(up_pad_do), .up_pad_oe(up_pad_oe), .sdr_di(sdr_di),
        .eth_rxd(eth_rxd), .pci_di(pci_di), .dqm_pad_di(dqm_pad_di),
        .dqm_pad_do(dqm_pad_do), .dqm_pad_oe(dqm_pad_oe), .dqm_clk(dqm_clk),
        .upper_mode(upper_mode), .ready(ready)
    );

    // observation ids
    localparam int O_RDY = 0, O_SEL = 1, O_SDO = 2, O_SOE = 3, O_PDI = 4, O_ADI = 5,
                   O_GDI = 6, O_UDO = 7, O_UOE = 8, O_SDI = 9, O_ERX = 10, O_PCI = 11,
                   O_QOE = 12, O_QDO = 13, O_QCK = 14, O_MOD = 15;

    typedef struct {
        string       req;
        int          id;
        logic [63:0] exp;
    } item_t;

    item_t sbq[$];
    int nchecks = 0;
    int nerr = 0;
    bit done = 0;

    function automatic logic [63:0] observe(int id);
        case (id)
            O_RDY: return 64'(ready);
            O_SEL: return 64'(cur_sel);
            O_SDO: return 64'(sh_pad_do);
            O_SOE: return 64'(sh_pad_oe);
            O_PDI: return 64'(prom_di);
            O_ADI: return 64'(alt_di);
            O_GDI: return 64'(gpio_di);
            O_UDO: return 64'(up_pad_do);
            O_UOE: return 64'(up_pad_oe);
            O_SDI: return 64'(sdr_di);
            O_ERX: return 64'(eth_rxd);
            O_PCI: return 64'(pci_di);
            O_QOE: return 64'(dqm_pad_oe);
            O_QDO: return 64'(dqm_pad_do);
            O_QCK: return 64'(dqm_clk);
            O_MOD: return 64'(upper_mode);
            default: return '0;
        endcase
    endfunction

    // driver side: queue an expectation
    task automatic push(string r, int id, logic [63:0] e);
        item_t it;
        it.req = r; it.id = id; it.exp = e;
        sbq.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // monitor: compare queued expectations at each falling edge
    initial begin : monitor
        item_t it;
        logic [63:0] act;
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                it = sbq.pop_front();
                act = observe(it.id);
                nchecks++;
                if (act !== it.exp) begin
                    nerr++;
                    $display("FAIL %s (obs %0d): actual=%h expected=%h", it.req, it.id, act, it.exp);
                end
            end
        end
    end

    task automatic boot(bit pa, bit nw, bit pc);
        rst_n = 1'b0;
        strap_prom_alt = pa; strap_mem_narrow = nw; strap_pci = pc;
        sel_we = 1'b0;
        push("R1", O_RDY, 0);
        push("R1", O_UOE, 0);
        repeat (3) step();
        rst_n = 1'b1;
        // after the first edge (LATCH -> INIT) still quiet
        push("R1", O_RDY, 0);
        push("R1", O_SOE, 0);
        push("R1", O_UOE, 0);
        push("R1", O_QOE, 0);
        step();
        step();
    endtask

    initial begin : driver
        // ---- boot 1: boot bus owns shared pins, full-width SDRAM
        boot(0, 0, 0);
        push("R1", O_RDY, 1);
        push("R2", O_SEL, 16'h0000);
        push("R3", O_SDO, 8'hA5);
        push("R3", O_SOE, 8'hF0);
        push("R5", O_PDI, 8'h5A);
        push("R5", O_ADI, 8'h08);   // only tied pins pass
        push("R5", O_GDI, 8'h5A);
        push("R6", O_MOD, 0);
        push("R6", O_UDO, 16'h1234);
        push("R6", O_UOE, 16'hFFFF);
        push("R6", O_SDI, 16'hBEEF);
        push("R6", O_ERX, 0);
        push("R6", O_PCI, 0);
        push("R9", O_QOE, 2'b11);
        push("R9", O_QDO, 2'b10);
        push("R9", O_QCK, 2'b00);
        step();
        sdr_oe = 1'b0;
        push("R6", O_UOE, 16'h0000);
        step();
        sdr_oe = 1'b1;
        // straps moved after capture: no effect
        strap_mem_narrow = 1; strap_pci = 1; strap_prom_alt = 1;
        step();
        push("R10", O_MOD, 0);
        push("R10", O_UOE, 16'hFFFF);
        push("R10", O_SEL, 16'h0000);
        step();

        // ---- boot 2: alternative functions, Ethernet on upper pins
        boot(1, 1, 0);
        push("R2", O_SEL, 16'h5555);
        push("R3", O_SDO, 8'h3C);
        push("R3", O_SOE, 8'h0F);
        push("R5", O_PDI, 8'h00);
        push("R5", O_ADI, 8'h5A);
        push("R7", O_MOD, 1);
        push("R7", O_UDO, 16'hA940);
        push("R7", O_UOE, 16'hFFC0);
        push("R7", O_ERX, 6'h2F);
        push("R7", O_SDI, 0);
        push("R9", O_QOE, 0);
        push("R9", O_QCK, 2'b01);
        step();
        // pin 7 -> GPIO
        sel_we = 1; sel_idx = 3'd7; sel_val = 2'b10;
        push("R4", O_SEL, 16'h9555);
        push("R3", O_SDO, 8'hBC);
        push("R3", O_SOE, 8'h8F);
        step();
        sel_we = 0;
        // pin 0 -> boot bus
        sel_we = 1; sel_idx = 3'd0; sel_val = 2'b00;
        push("R4", O_SEL, 16'h9554);
        push("R3", O_SDO, 8'hBD);
        push("R3", O_SOE, 8'h8E);
        push("R5", O_PDI, 8'h00);
        push("R5", O_ADI, 8'h5A);
        step();
        // reserved code on pin 1
        sel_idx = 3'd1; sel_val = 2'b11;
        push("R4", O_SEL, 16'h9554);
        push("R4", O_SDO, 8'hBD);
        step();
        sel_we = 0;
        // pad change with pin 0 on the boot bus
        sh_pad_di = 8'h5B;
        push("R5", O_PDI, 8'h01);
        push("R5", O_ADI, 8'h5A);
        push("R5", O_GDI, 8'h5B);
        step();
        sh_pad_di = 8'h5A;

        // ---- boot 3: boot bus, PCI on upper pins
        boot(0, 1, 1);
        push("R2", O_SEL, 16'h0000);
        push("R8", O_MOD, 2);
        push("R8", O_UDO, 16'hC3A5);
        push("R8", O_UOE, 16'h00FF);
        push("R8", O_PCI, 16'hBEEF);
        push("R8", O_SDI, 0);
        push("R8", O_ERX, 0);
        push("R9", O_QOE, 0);
        push("R9", O_QCK, 2'b01);
        step();
        pci_oe = 16'hF00F;
        up_pad_di = 16'h0F0F;
        push("R8", O_UOE, 16'hF00F);
        push("R8", O_PCI, 16'h0F0F);
        step();
        step();

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nerr++;
            nchecks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

endmodule